// File: doc/BRIEF.md
# Scatter-Gather DMA Engine

This block is the bus-master side of a disk controller. The device arms it, and then a start command gives it the base of a descriptor table in memory, the transfer direction and the number of bytes the command still has to move. The engine fetches descriptors one at a time. Each descriptor names a memory region by its base address, its byte count and an end-of-table flag. The engine moves that region as a series of memory requests, and none of those requests crosses a page boundary.

The memory side uses a busy/grant handshake. If the engine sees busy when it wants the bus, it drops its request and waits a fixed number of cycles. It then retries the same step. At the end of the table the engine checks that the command's byte budget has been used up exactly. It then reports done, or a transfer error. An abort sent while the engine is armed or working ends the command with a command error. Data storage, register decoding and interrupts are handled by neighbouring blocks.

Top module: `sgdma_engine`

## Requirements
- R1: While reset is high and in the cycle after it is released, `mem_req`, `done`, `cmd_err` and `xfer_err` are all low.
- R2: A `start` is accepted only after `arm` has moved the engine into its armed state; a `start` in the idle state has no effect. Once a start is accepted, the first descriptor fetch is requested in the next cycle. That fetch has `mem_is_desc`=1, `mem_len`=8, `mem_we`=0, and its address is `table_base` with bits 1:0 cleared.
- R3: A descriptor is the 64-bit word returned on `mem_rdata` with the grant. Bits 31:0 hold the region base. Bits 47:32 hold the byte count, where 0 means 65536. Bit 63 is the end-of-table flag. Each fetch advances the table pointer by 8 bytes.
- R4: A data request is never longer than `PAGE_BYTES` and never crosses a `PAGE_BYTES` boundary. When a region would cross a boundary, the request is cut so that it ends exactly on that boundary.
- R5: A region is issued as consecutive data requests at ascending addresses, with no gaps, until its whole byte count has been covered.
- R6: When `to_disk`=1, data requests read memory (`mem_we`=0). When `to_disk`=0, they write memory (`mem_we`=1).
- R7: If `mem_busy` is high while the engine wants to fetch or transfer, it raises no request for `BACKOFF_CYC` cycles. It then retries the same step at the same address.
- R8: Suppose the last request of an end-of-table region is granted and it uses up the command's remaining bytes exactly. Then `done` pulses for one cycle in the next cycle, and the engine returns to idle.
- R9: If an end-of-table region finishes while command bytes remain, `xfer_err` pulses instead of `done`.
- R10: If a region's byte count exceeds the command's remaining bytes, `xfer_err` pulses and no data request is made for that region.
- R11: If a region would run past address 2^32, `xfer_err` pulses and no data request is made. A region that ends exactly at 2^32 is legal.
- R12: An `abort` while the engine is armed or working makes `cmd_err` pulse in the next cycle and returns the engine to idle. An `abort` while idle has no effect.
- R13: After a region without the end-of-table flag completes, the engine fetches the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Device arms the engine for one command |
| start | input | 1 | Start command (accepted when armed) |
| table_base | input | 32 | Descriptor table address, bits 1:0 ignored |
| to_disk | input | 1 | 1: data moves to disk (memory read) |
| cmd_bytes | input | CNT_W | Bytes the command has left to move |
| abort | input | 1 | Abandon the command |
| mem_req | output | 1 | Memory request valid |
| mem_is_desc | output | 1 | Request is a descriptor fetch |
| mem_we | output | 1 | Request writes memory |
| mem_addr | output | 32 | Request byte address |
| mem_len | output | log2(PAGE_BYTES)+1 | Request length in bytes |
| mem_busy | input | 1 | Memory side busy, back off |
| mem_grant | input | 1 | Request accepted this cycle |
| mem_rdata | input | 64 | Descriptor word, valid with a descriptor grant |
| done | output | 1 | Command completed (one-cycle pulse) |
| cmd_err | output | 1 | Command aborted (one-cycle pulse) |
| xfer_err | output | 1 | Transfer error (one-cycle pulse) |

## Verification
The first descriptor request is combinational from state, so it is visible in the cycle after the edge that samples `start`. A grant acts at the edge where it is sampled. The registered pulses `done`, `cmd_err` and `xfer_err` appear one cycle after the edge that decides them. A busy sample holds the request off for exactly `BACKOFF_CYC` cycles.

The bench drives inputs just after the rising edge and logs everything on the falling edge, together with a cycle index. Timing checks compare those indices: start to first fetch is 1, last grant to done is 1, and busy sample to retry is `BACKOFF_CYC`. They do not rely on absolute delays.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    localparam int DESC_BYTES = 8;
    localparam int REGION_W   = 17;   // region byte count, up to 65536

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_FETCH,
        ST_CHECK,
        ST_BURST,
        ST_WAIT
    } st_e;

    typedef struct packed {
        logic [31:0]         base;
        logic [REGION_W-1:0] len;
        logic                eot;
    } desc_t;

    function automatic desc_t desc_unpack(input logic [63:0] w);
        desc_t d;
        d.base = w[31:0];
        d.len  = (w[47:32] == 16'h0) ? REGION_W'(17'h10000) : {1'b0, w[47:32]};
        d.eot  = w[63];
        return d;
    endfunction

endpackage

// File: rtl/sgdma_desc_decode.sv
module sgdma_desc_decode
    import sgdma_pkg::*;
(
    input  logic [63:0] word,
    output desc_t       desc
);
    always_comb desc = desc_unpack(word);
endmodule

// File: rtl/sgdma_page_split.sv
module sgdma_page_split
    import sgdma_pkg::*;
#(
    parameter int PAGE_BYTES = 4096
) (
    input  logic [31:0]                   addr,
    input  logic [REGION_W-1:0]           remain,
    output logic [$clog2(PAGE_BYTES):0]   chunk,
    output logic                          last
);
    localparam int PW    = $clog2(PAGE_BYTES);
    localparam int LEN_W = PW + 1;
    localparam int CW    = ((LEN_W > REGION_W) ? LEN_W : REGION_W) + 1;

    logic [CW-1:0] room;
    logic [CW-1:0] rem_x;

    always_comb begin
        room  = CW'(PAGE_BYTES) - CW'(addr[PW-1:0]);
        rem_x = CW'(remain);
        last  = (rem_x <= room);
        chunk = last ? LEN_W'(rem_x) : LEN_W'(room);
    end
endmodule

// File: rtl/sgdma_backoff.sv
module sgdma_backoff #(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (load)      cnt <= CW'(CYC - 1);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
    import sgdma_pkg::*;
#(
    parameter int PAGE_BYTES  = 4096,
    parameter int BACKOFF_CYC = 8,
    parameter int CNT_W       = 18
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        arm,
    input  logic                        start,
    input  logic [31:0]                 table_base,
    input  logic                        to_disk,
    input  logic [CNT_W-1:0]            cmd_bytes,
    input  logic                        abort,
    output logic                        mem_req,
    output logic                        mem_is_desc,
    output logic                        mem_we,
    output logic [31:0]                 mem_addr,
    output logic [$clog2(PAGE_BYTES):0] mem_len,
    input  logic                        mem_busy,
    input  logic                        mem_grant,
    input  logic [63:0]                 mem_rdata,
    output logic                        done,
    output logic                        cmd_err,
    output logic                        xfer_err
);
    localparam int LEN_W = $clog2(PAGE_BYTES) + 1;

    st_e               st, ret_st;
    logic [31:0]       tbl_ptr;
    desc_t             cur;
    desc_t             fetched;
    logic [CNT_W-1:0]  bytes_left;
    logic              mem_rd_dir;
    logic [LEN_W-1:0]  chunk;
    logic              chunk_last;
    logic              bo_load;
    logic              bo_expired;
    logic              overrun;
    logic              wraps;

    sgdma_desc_decode dec_i (
        .word (mem_rdata),
        .desc (fetched)
    );

    sgdma_page_split #(.PAGE_BYTES(PAGE_BYTES)) split_i (
        .addr   (cur.base),
        .remain (cur.len),
        .chunk  (chunk),
        .last   (chunk_last)
    );

    sgdma_backoff #(.CYC(BACKOFF_CYC)) bo_i (
        .clk     (clk),
        .rst     (rst),
        .load    (bo_load),
        .expired (bo_expired)
    );

    // Outward request, built from state only (plus busy gating)
    always_comb begin
        mem_req     = ((st == ST_FETCH) || (st == ST_BURST)) && !mem_busy;
        mem_is_desc = (st == ST_FETCH);
        mem_addr    = (st == ST_FETCH) ? tbl_ptr : cur.base;
        mem_len     = (st == ST_FETCH) ? LEN_W'(DESC_BYTES) : chunk;
        mem_we      = (st == ST_BURST) && !mem_rd_dir;
        bo_load     = ((st == ST_FETCH) || (st == ST_BURST)) && mem_busy;
        overrun     = 32'(cur.len) > 32'(bytes_left);
        wraps       = ({1'b0, cur.base} + 33'(cur.len)) > 33'h1_0000_0000;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            ret_st     <= ST_FETCH;
            tbl_ptr    <= '0;
            cur        <= '0;
            bytes_left <= '0;
            mem_rd_dir <= 1'b0;
            done       <= 1'b0;
            cmd_err    <= 1'b0;
            xfer_err   <= 1'b0;
        end else begin
            done     <= 1'b0;
            cmd_err  <= 1'b0;
            xfer_err <= 1'b0;
            if (abort && (st != ST_IDLE)) begin
                st      <= ST_IDLE;
                cmd_err <= 1'b1;
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        if (arm) st <= ST_ARMED;
                    end
                    ST_ARMED: begin
                        if (start) begin
                            tbl_ptr    <= {table_base[31:2], 2'b00};
                            bytes_left <= cmd_bytes;
                            mem_rd_dir <= to_disk;
                            st         <= ST_FETCH;
                        end
                    end
                    ST_FETCH: begin
                        if (mem_busy) begin
                            ret_st <= ST_FETCH;
                            st     <= ST_WAIT;
                        end else if (mem_grant) begin
                            cur     <= fetched;
                            tbl_ptr <= tbl_ptr + 32'(DESC_BYTES);
                            st      <= ST_CHECK;
                        end
                    end
                    ST_CHECK: begin
                        if (overrun || wraps) begin
                            xfer_err <= 1'b1;
                            st       <= ST_IDLE;
                        end else begin
                            st <= ST_BURST;
                        end
                    end
                    ST_BURST: begin
                        if (mem_busy) begin
                            ret_st <= ST_BURST;
                            st     <= ST_WAIT;
                        end else if (mem_grant) begin
                            cur.base   <= cur.base + 32'(chunk);
                            cur.len    <= cur.len - REGION_W'(chunk);
                            bytes_left <= bytes_left - CNT_W'(chunk);
                            if (chunk_last) begin
                                if (!cur.eot) begin
                                    st <= ST_FETCH;
                                end else begin
                                    st <= ST_IDLE;
                                    if (bytes_left == CNT_W'(chunk)) done     <= 1'b1;
                                    else                             xfer_err <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_WAIT: begin
                        if (bo_expired) st <= ret_st;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sgdma_engine_chk.sv
module sgdma_engine_chk #(
    parameter int PAGE_BYTES = 4096
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        abort,
    input logic                        mem_req,
    input logic                        mem_is_desc,
    input logic                        mem_we,
    input logic [31:0]                 mem_addr,
    input logic [$clog2(PAGE_BYTES):0] mem_len,
    input logic                        mem_grant,
    input logic                        done,
    input logic                        cmd_err,
    input logic                        xfer_err
);
    localparam int PW = $clog2(PAGE_BYTES);

    a_r4_page_bound: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_is_desc) |->
            ((mem_len != '0) && ((33'(mem_addr[PW-1:0]) + 33'(mem_len)) <= 33'(PAGE_BYTES))));

    a_r2_desc_shape: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_is_desc) |->
            ((mem_addr[1:0] == 2'b00) && (mem_len == ($clog2(PAGE_BYTES)+1)'(8)) && !mem_we));

    a_r8_done_after_grant: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_req && mem_grant && !mem_is_desc));

    a_r12_err_after_abort: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $past(abort));

    a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, cmd_err, xfer_err}));

    a_r6_dir_steady: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_is_desc && $past(mem_req && !mem_is_desc)) |-> $stable(mem_we));
endmodule

bind sgdma_engine sgdma_engine_chk #(.PAGE_BYTES(PAGE_BYTES)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .abort       (abort),
    .mem_req     (mem_req),
    .mem_is_desc (mem_is_desc),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_len     (mem_len),
    .mem_grant   (mem_grant),
    .done        (done),
    .cmd_err     (cmd_err),
    .xfer_err    (xfer_err)
);

// File: tb/sgdma_engine_tb_top.sv
module sgdma_engine_tb_top;
    localparam int PAGE = 4096;
    localparam int BO   = 8;
    localparam int CW   = 18;
    localparam int LW   = $clog2(PAGE) + 1;

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] cnt;
        logic [17:0] cmd;
        logic [7:0]  nreq;
        logic [15:0] flen;
        logic [15:0] llen;
        logic        ok;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_1000, 16'd512,    18'd512,   8'd1,  16'd512,  16'd512,  1'b1},
        '{32'h0000_1F00, 16'd512,    18'd512,   8'd2,  16'd256,  16'd256,  1'b1},
        '{32'h0000_2000, 16'h3000,   18'h3000,  8'd3,  16'd4096, 16'd4096, 1'b1},
        '{32'h0000_2E00, 16'h2400,   18'h2400,  8'd4,  16'd512,  16'd512,  1'b1},
        '{32'h0001_0000, 16'h0000,   18'h10000, 8'd16, 16'd4096, 16'd4096, 1'b1},
        '{32'h0000_3000, 16'd1024,   18'd512,   8'd0,  16'd0,    16'd0,    1'b0},
        '{32'h0000_3000, 16'd512,    18'd1024,  8'd1,  16'd512,  16'd512,  1'b0},
        '{32'hFFFF_FF00, 16'd512,    18'd512,   8'd0,  16'd0,    16'd0,    1'b0},
        '{32'hFFFF_F000, 16'd4096,   18'd4096,  8'd1,  16'd4096, 16'd4096, 1'b1}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst = 1'b1;
    logic            arm = 1'b0, start = 1'b0, to_disk = 1'b1, abort = 1'b0;
    logic [31:0]     table_base = '0;
    logic [CW-1:0]   cmd_bytes = '0;
    logic            mem_req, mem_is_desc, mem_we, mem_busy, mem_grant;
    logic [31:0]     mem_addr;
    logic [LW-1:0]   mem_len;
    logic [63:0]     mem_rdata;
    logic            done, cmd_err, xfer_err;
    logic            bsy = 1'b0;

    logic [63:0]     tbl [4];
    logic [31:0]     tbase = 32'h100;
    logic [31:0]     toff;

    assign mem_busy  = bsy;
    assign mem_grant = mem_req;
    always_comb begin
        toff      = mem_addr - tbase;
        mem_rdata = (toff[31:5] == '0) ? tbl[toff[4:3]] : 64'h0;
    end

    sgdma_engine #(.PAGE_BYTES(PAGE), .BACKOFF_CYC(BO), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .arm(arm), .start(start), .table_base(table_base),
        .to_disk(to_disk), .cmd_bytes(cmd_bytes), .abort(abort),
        .mem_req(mem_req), .mem_is_desc(mem_is_desc), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_busy(mem_busy),
        .mem_grant(mem_grant), .mem_rdata(mem_rdata),
        .done(done), .cmd_err(cmd_err), .xfer_err(xfer_err)
    );

    // Falling-edge logger, cleared by each start
    int          cyc = 0, start_cyc = 0, last_gnt_cyc = 0, done_cyc = 0;
    int          n_data = 0, n_desc = 0;
    logic [31:0] d_addr [32];
    logic [15:0] d_len  [32];
    logic        d_we   [32];
    logic [31:0] f_addr [8];
    int          f_cyc  [8];
    logic        saw_done = 1'b0, saw_xerr = 1'b0, saw_cerr = 1'b0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (start) begin
            start_cyc <= cyc;
            n_data <= 0; n_desc <= 0;
            saw_done <= 1'b0; saw_xerr <= 1'b0; saw_cerr <= 1'b0;
        end else begin
            if (mem_req && mem_grant) begin
                if (mem_is_desc) begin
                    if (n_desc < 8) begin
                        f_addr[n_desc] <= mem_addr;
                        f_cyc[n_desc]  <= cyc;
                    end
                    n_desc <= n_desc + 1;
                end else begin
                    if (n_data < 32) begin
                        d_addr[n_data] <= mem_addr;
                        d_len[n_data]  <= 16'(mem_len);
                        d_we[n_data]   <= mem_we;
                    end
                    n_data <= n_data + 1;
                    last_gnt_cyc <= cyc;
                end
            end
            if (done) begin saw_done <= 1'b1; done_cyc <= cyc; end
            if (xfer_err) saw_xerr <= 1'b1;
            if (cmd_err)  saw_cerr <= 1'b1;
        end
    end

    int nchk = 0, nfail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic arm_start(input logic [31:0] base, input logic dir, input logic [CW-1:0] nb);
        tick(); arm = 1'b1;
        tick(); arm = 1'b0; start = 1'b1; table_base = base; to_disk = dir; cmd_bytes = nb;
        tick(); start = 1'b0;
    endtask

    task automatic wait_end();
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (saw_done || saw_xerr || saw_cerr) break;
        end
        @(negedge clk);
    endtask

    function automatic logic [63:0] mkdesc(input logic [31:0] b, input logic [15:0] c, input logic e);
        return {e, 15'h0, c, b};
    endfunction

    initial begin
        repeat (40000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) tbl[i] = '0;
        repeat (3) tick();
        @(negedge clk);
        chk("R1 req in reset", {31'h0, mem_req}, 0);
        chk("R1 pulses in reset", {29'h0, done, cmd_err, xfer_err}, 0);
        tick(); rst = 1'b0;
        @(negedge clk);
        chk("R1 req after reset", {31'h0, mem_req}, 0);
        chk("R1 pulses after reset", {29'h0, done, cmd_err, xfer_err}, 0);

        // Vector table: single end-of-table region per case
        for (int i = 0; i < NV; i++) begin
            tbl[0] = mkdesc(VEC[i].base, VEC[i].cnt, 1'b1);
            arm_start(32'h100, 1'b1, VEC[i].cmd);
            wait_end();
            chk($sformatf("R5 case%0d request count", i), n_data, 32'(VEC[i].nreq));
            if (VEC[i].nreq != 0) begin
                chk($sformatf("R4 case%0d first len", i), 32'(d_len[0]), 32'(VEC[i].flen));
                chk($sformatf("R4 case%0d last len", i), 32'(d_len[VEC[i].nreq-1]), 32'(VEC[i].llen));
                chk($sformatf("R5 case%0d first addr", i), d_addr[0], VEC[i].base);
            end
            if (VEC[i].ok) chk($sformatf("R8 case%0d done", i), {30'h0, saw_done, saw_xerr}, 32'h2);
            else chk($sformatf("R9 R10 R11 case%0d xfer_err", i), {30'h0, saw_done, saw_xerr}, 32'h1);
        end
        // contiguity for the four-request case
        tbl[0] = mkdesc(32'h2E00, 16'h2400, 1'b1);
        arm_start(32'h100, 1'b1, 18'h2400);
        wait_end();
        chk("R5 second addr", d_addr[1], 32'h3000);
        chk("R5 fourth addr", d_addr[3], 32'h5000);

        // Chain of two descriptors, unaligned table base
        tbl[0] = mkdesc(32'h5000, 16'd512, 1'b0);
        tbl[1] = mkdesc(32'h7F00, 16'd512, 1'b1);
        arm_start(32'h103, 1'b1, 18'd1024);
        wait_end();
        chk("R2 first fetch addr masked", f_addr[0], 32'h100);
        chk("R2 fetch one cycle after start", 32'(f_cyc[0] - start_cyc), 1);
        chk("R3 R13 second fetch addr", f_addr[1], 32'h108);
        chk("R13 fetch count", n_desc, 2);
        chk("R4 chain data requests", n_data, 3);
        chk("R4 split at boundary", d_addr[2], 32'h8000);
        chk("R8 done in chain", {31'h0, saw_done}, 1);
        chk("R8 done one cycle after last grant", 32'(done_cyc - last_gnt_cyc), 1);
        chk("R6 to_disk=1 reads memory", {31'h0, d_we[0]}, 0);

        // Direction: read from disk writes memory
        tbl[0] = mkdesc(32'h1000, 16'd512, 1'b1);
        arm_start(32'h100, 1'b0, 18'd512);
        wait_end();
        chk("R6 to_disk=0 writes memory", {31'h0, d_we[0]}, 1);

        // Backoff on busy during the fetch step
        bsy = 1'b1;
        arm_start(32'h100, 1'b1, 18'd512);
        tick(); bsy = 1'b0;
        begin
            int first_k;
            first_k = 0;
            for (int k = 1; k <= 30; k++) begin
                @(negedge clk);
                if (mem_req && first_k == 0) begin
                    first_k = k;
                    chk("R7 retry same step addr", mem_addr, 32'h100);
                end
            end
            chk("R7 backoff length", first_k, BO + 1);
        end
        wait_end();
        chk("R7 completes after backoff", {31'h0, saw_done}, 1);

        // Start without arm is ignored
        tick(); start = 1'b1; table_base = 32'h100; cmd_bytes = 18'd512;
        tick(); start = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 start while idle ignored", n_desc, 0);

        // Abort while idle is ignored
        tick(); abort = 1'b1;
        tick(); abort = 1'b0;
        @(negedge clk);
        chk("R12 abort while idle ignored", {31'h0, cmd_err}, 0);

        // Abort while armed
        tick(); arm = 1'b1;
        tick(); arm = 1'b0; abort = 1'b1;
        tick(); abort = 1'b0;
        @(negedge clk);
        chk("R12 abort while armed", {31'h0, cmd_err}, 1);
        tick(); start = 1'b1;
        tick(); start = 1'b0;
        repeat (4) @(negedge clk);
        chk("R12 idle after abort", n_desc, 0);

        // Abort while transferring
        tbl[0] = mkdesc(32'h10000, 16'h0000, 1'b1);
        arm_start(32'h100, 1'b1, 18'h10000);
        repeat (3) tick();
        abort = 1'b1;
        tick(); abort = 1'b0;
        wait_end();
        chk("R12 abort mid transfer", {30'h0, saw_cerr, saw_done}, 32'h2);
        chk("R12 no request after abort", {31'h0, mem_req}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule